// File: doc/BRIEF.md
# Parity-Group Self-Checking Output Checker

This block watches the 16-bit result of a combinational function together with its predicted check bits and reports whether that result is still a codeword. The result bits are split into contiguous parity groups, and each group carries one predicted check bit. Every group has its own parity checker that produces a pair of complementary rails. A balanced tree of two-rail cells then reduces all group pairs to a single rail pair. A complementary pair (01 or 10) means the result is a codeword. A pair with equal rails (00 or 11) means an error.

Group width is a parameter. With a group width of 4 (the default) there are four groups and four check bits. A width of 2 gives eight groups, and a width of 16 gives one whole-word parity. Narrow groups cost more check bits but allow more logic sharing between the functional outputs. Only one rail pair crosses the chip to the error handler. The merged pair is registered once, so it is valid one clock after the inputs it describes.

Top module: `parity_group_checker`

## Requirements
- R1: While reset is active, and in the first cycle after reset is released, the output pair is railF=0, railG=1.
- R2: The output pair sampled after a rising clock edge describes the inputs present at that edge, with exactly one register of latency.
- R3: Group k holds data bits k*GROUP_W to k*GROUP_W+GROUP_W-1 and check bit k. If every group has even parity over its data bits and its check bit, the output pair is complementary.
- R4: Inverting any single data bit of a valid word makes railF equal railG.
- R5: Inverting any single check bit of a valid word makes railF equal railG.
- R6: Inverting one bit in each of two different groups (data or check) makes railF equal railG.
- R7: Inverting two bits inside the same group, including a data bit together with that group's own check bit, leaves the output pair complementary (not detectable).
- R8: Across valid words, both complementary values 01 and 10 appear at the output, so every rail toggles during normal operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| dataWord | input | DATA_W (16) | Functional output bits under check |
| checkBits | input | DATA_W/GROUP_W (4) | Predicted even-parity bit per group, bit k for group k |
| railF | output | 1 | First rail of the merged error pair |
| railG | output | 1 | Second rail of the merged error pair |

## Verification
The assertions accept any value on the data and check inputs, and they classify each sampled word by its group parities. They rely on the inputs being settled at every rising edge. The stability property also assumes that a value held over two edges describes a single, steady stimulus. The bench changes inputs only at falling edges and holds each injected error for exactly one cycle. Every word, clean or corrupted, is therefore sampled exactly once. Words that put two errors in one group are applied deliberately to expose the blind spot of parity inside a group.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

  // Two-rail pair: complementary values mean "codeword"
  typedef struct packed {
    logic f;
    logic g;
  } railPair_t;

  localparam railPair_t RAIL_IDLE = '{f: 1'b0, g: 1'b1};

  // Two-rail merge: complementary in, complementary out; any equal pair in, equal pair out
  function automatic railPair_t railMerge(input railPair_t a, input railPair_t b);
    railPair_t r;
    r.f = (a.f & b.f) | (a.g & b.g);
    r.g = (a.f & b.g) | (a.g & b.f);
    return r;
  endfunction

endpackage

// File: rtl/pgc_group_parity.sv
module pgc_group_parity
  import pgc_pkg::*;
#(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] members,
  input  logic               checkBit,
  output railPair_t          pair
);

  logic evenAcc;
  logic oddAcc;

  // Even-position members plus the check bit feed one rail; odd-position members feed the other, inverted
  always_comb begin
    evenAcc = checkBit;
    oddAcc  = 1'b0;
    for (int i = 0; i < GROUP_W; i++) begin
      if ((i % 2) == 0) evenAcc = evenAcc ^ members[i];
      else              oddAcc  = oddAcc ^ members[i];
    end
  end

  assign pair.f = evenAcc;
  assign pair.g = ~oddAcc;

endmodule

// File: rtl/pgc_rail_cell.sv
module pgc_rail_cell
  import pgc_pkg::*;
(
  input  railPair_t a,
  input  railPair_t b,
  output railPair_t y
);

  assign y = railMerge(a, b);

endmodule

// File: rtl/pgc_rail_tree.sv
module pgc_rail_tree
  import pgc_pkg::*;
#(
  parameter int PAIRS = 4
) (
  input  railPair_t [PAIRS-1:0] leaves,
  output railPair_t             root
);

  localparam int NODES = 2 * PAIRS - 1;

  // Heap layout: node 0 is the root, leaves occupy the last PAIRS slots
  railPair_t node [NODES];

  for (genvar i = 0; i < PAIRS; i++) begin : g_leaf
    assign node[PAIRS - 1 + i] = leaves[i];
  end

  for (genvar k = 0; k < PAIRS - 1; k++) begin : g_inner
    pgc_rail_cell u_cell (
      .a(node[2 * k + 1]),
      .b(node[2 * k + 2]),
      .y(node[k])
    );
  end

  assign root = node[0];

endmodule

// File: rtl/parity_group_checker.sv
module parity_group_checker
  import pgc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int GROUP_W = 4,
  localparam int NUM_GROUPS = DATA_W / GROUP_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DATA_W-1:0]     dataWord,
  input  logic [NUM_GROUPS-1:0] checkBits,
  output logic                  railF,
  output logic                  railG
);

  if (GROUP_W < 2 || (DATA_W % GROUP_W) != 0) begin : g_bad_cfg
    $error("GROUP_W must be at least 2 and divide DATA_W");
  end

  railPair_t [NUM_GROUPS-1:0] groupPairs;
  railPair_t                  mergedPair;
  railPair_t                  railQ;

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_group
    pgc_group_parity #(.GROUP_W(GROUP_W)) u_parity (
      .members (dataWord[k*GROUP_W +: GROUP_W]),
      .checkBit(checkBits[k]),
      .pair    (groupPairs[k])
    );
  end

  pgc_rail_tree #(.PAIRS(NUM_GROUPS)) u_tree (
    .leaves(groupPairs),
    .root  (mergedPair)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) railQ <= RAIL_IDLE;
    else       railQ <= mergedPair;
  end

  assign railF = railQ.f;
  assign railG = railQ.g;

endmodule

// File: rtl/parity_group_checker_chk.sv
module parity_group_checker_chk #(
  parameter int DATA_W  = 16,
  parameter int GROUP_W = 4,
  localparam int NUM_GROUPS = DATA_W / GROUP_W
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [DATA_W-1:0]     dataWord,
  input logic [NUM_GROUPS-1:0] checkBits,
  input logic                  railF,
  input logic                  railG
);

  logic allGroupsEven;

  always_comb begin
    allGroupsEven = 1'b1;
    for (int k = 0; k < NUM_GROUPS; k++) begin
      if ((^dataWord[k*GROUP_W +: GROUP_W]) != checkBits[k]) allGroupsEven = 1'b0;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (railF == 1'b0 && railG == 1'b1));

  // R3
  codeword_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    allGroupsEven |=> (railF != railG));

  // R4 R5 R6
  noncode_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !allGroupsEven |=> (railF == railG));

  // R2
  steady_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $stable(dataWord) && $stable(checkBits)) |=> $stable({railF, railG}));

endmodule

bind parity_group_checker parity_group_checker_chk #(
  .DATA_W (DATA_W),
  .GROUP_W(GROUP_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .dataWord (dataWord),
  .checkBits(checkBits),
  .railF    (railF),
  .railG    (railG)
);

// File: tb/parity_group_checker_bench.sv
module parity_group_checker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int GROUP_W    = 4;
  localparam int NGRP       = DATA_W / GROUP_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] dataWord = '0;
  logic [NGRP-1:0]   checkBits = '0;
  logic              railF;
  logic              railG;

  int testCount = 0;
  int failCount = 0;
  bit seen01 = 0;
  bit seen10 = 0;

  bit    wantQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_group_checker #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) u_parity_group_checker (
    .clk(clk), .rstN(rstN), .dataWord(dataWord), .checkBits(checkBits),
    .railF(railF), .railG(railG)
  );

  function automatic logic [NGRP-1:0] predict(input logic [DATA_W-1:0] d);
    logic [NGRP-1:0] c;
    for (int k = 0; k < NGRP; k++) c[k] = ^d[k*GROUP_W +: GROUP_W];
    return c;
  endfunction

  // Driver: apply a word at the falling edge and record what the pair must look like
  task automatic drive(input logic [DATA_W-1:0] d, input logic [NGRP-1:0] c,
                       input bit wantCode, input string tag);
    @(negedge clk);
    dataWord  = d;
    checkBits = c;
    wantQ.push_back(wantCode);
    tagQ.push_back(tag);
  endtask

  // Monitor: sample just after each rising edge and compare against the oldest expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (wantQ.size() > 0) begin
        bit    want;
        string tag;
        bit    isCode;
        want   = wantQ.pop_front();
        tag    = tagQ.pop_front();
        isCode = (railF != railG);
        testCount++;
        if (isCode != want) begin
          failCount++;
          $display("FAIL %s: pair=%b%b complementary=%0d expected complementary=%0d",
                   tag, railF, railG, isCode, want);
        end
        if (isCode && want) begin
          if (railF == 1'b0) seen01 = 1;
          else               seen10 = 1;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failCount++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] d;
    logic [NGRP-1:0]   c;

    // R1: idle pair during reset
    repeat (3) @(negedge clk);
    testCount++;
    if (!(railF == 1'b0 && railG == 1'b1)) begin
      failCount++;
      $display("FAIL R1: pair=%b%b expected=01", railF, railG);
    end
    rstN = 1'b1;

    // R3: clean random words
    for (int n = 0; n < 24; n++) begin
      d = DATA_W'($urandom);
      drive(d, predict(d), 1'b1, "R3");
    end
    drive('0, '0, 1'b1, "R3");
    drive('1, predict('1), 1'b1, "R3");

    // R2: alternating clean and corrupted words, one cycle each
    for (int n = 0; n < 6; n++) begin
      d = DATA_W'($urandom);
      drive(d, predict(d) ^ NGRP'(n % 2), (n % 2) == 0, "R2");
    end

    // R4: every single data bit
    for (int b = 0; b < DATA_W; b++) begin
      d = DATA_W'($urandom);
      drive(d ^ (DATA_W'(1) << b), predict(d), 1'b0, "R4");
    end

    // R5: every single check bit
    for (int k = 0; k < NGRP; k++) begin
      d = DATA_W'($urandom);
      drive(d, predict(d) ^ (NGRP'(1) << k), 1'b0, "R5");
    end

    // R6: one error in each of two different groups
    for (int k = 0; k < NGRP - 1; k++) begin
      d = DATA_W'($urandom);
      drive(d ^ (DATA_W'(1) << (k*GROUP_W)) ^ (DATA_W'(1) << ((k+1)*GROUP_W + 3)),
            predict(d), 1'b0, "R6");
      d = DATA_W'($urandom);
      drive(d ^ (DATA_W'(1) << (k*GROUP_W + 1)), predict(d) ^ (NGRP'(1) << (k+1)), 1'b0, "R6");
    end

    // R7: two errors inside one group are not flagged
    for (int k = 0; k < NGRP; k++) begin
      d = DATA_W'($urandom);
      drive(d ^ (DATA_W'(3) << (k*GROUP_W)), predict(d), 1'b1, "R7");
      d = DATA_W'($urandom);
      c = predict(d) ^ (NGRP'(1) << k);
      drive(d ^ (DATA_W'(1) << (k*GROUP_W + 2)), c, 1'b1, "R7");
    end

    drive('0, '0, 1'b1, "R3");
    repeat (4) @(negedge clk);

    // R8: both complementary values seen on clean words
    testCount++;
    if (!(seen01 && seen10)) begin
      failCount++;
      $display("FAIL R8: seen01=%0d seen10=%0d expected both 1", seen01, seen10);
    end

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule